// File: doc/BRIEF.md
# Addressed Serial Receiver with Station Filtering

This block receives asynchronous serial characters and decides, frame by frame, which of them the local host gets to see. Several stations share one line. The sender first sends an address character that names one station, then sends the data characters meant for that station. Every character carries one extra flag bit after its data bits. When the flag is 1, the character is an address. When it is 0, the character is payload.

Each receiver holds its own station number. An address character that matches the station number opens the receiver, and the receiver hands that address to the host. An address character that does not match closes the receiver, so the payload characters that follow are dropped. A separate control pulse also closes the receiver, and it stays closed until its own address comes by.

With the addressing mode turned off, the same receiver works as a plain UART. In that mode every well-formed character is delivered. An optional parity check replaces the flag bit: the bit after the data is then a parity bit, and it is checked.

The line is sampled from a 16x oversampling enable. The data length can be 7 or 8 bits, and each frame has one or two stop bits.

Top module: `mp_uart_rx`

## Requirements
- R1: A frame is a low start bit, then the data bits LSB first (7 bits when `cfgSevenBit`=1, else 8), then one extra bit when `cfgMpEnable` or `cfgParityEn` is 1, then one stop bit (two when `cfgTwoStop`=1). Each bit lasts 16 `tick16` pulses and is sampled near its middle. A low pulse that is high again at the middle of the start bit is ignored, and the next frame is received normally.
- R2: With `cfgMpEnable`=0, every frame that has good stop bits and good parity is delivered with `rxIsId`=0. In 7-bit mode, bit 7 of `rxData` is 0.
- R3: With `cfgMpEnable`=1, the extra bit is the address flag: 1 marks an address frame and 0 marks a data frame. `cfgParityEn` and `cfgParityOdd` then have no effect: nothing is checked as parity, and `parityErr` stays 0.
- R4: An address frame that equals `stationId` is delivered with `rxIsId`=1, and `waitId` becomes 0. In 7-bit mode only bits 6:0 of `stationId` are compared.
- R5: An address frame that does not equal `stationId` is not delivered, and `waitId` becomes 1.
- R6: In addressing mode, a data frame is delivered with `rxIsId`=0 only while `waitId`=0. Otherwise it is dropped.
- R7: After reset, `waitId`=1 and `rxValid`, `rxData`, `rxIsId`, `frameErr`, `parityErr` and `overrun` are all 0. A `waitIdSet` pulse sets `waitId` to 1.
- R8: A low sample on any stop bit sets `frameErr`. That frame is neither delivered nor allowed to change `waitId`.
- R9: With `cfgMpEnable`=0 and `cfgParityEn`=1, the ones count over the data bits and the parity bit must be even (`cfgParityOdd`=0) or odd (`cfgParityOdd`=1). On a mismatch, `parityErr` is set and the frame is dropped.
- R10: A frame that would be delivered while the previous byte is still unread sets `overrun` and is dropped, and `rxData` keeps the older byte. A `hostRead` pulse marks the byte as read and clears `frameErr`, `parityErr` and `overrun`.
- R11: Each delivery raises `rxValid` for exactly one clock. `rxData` and `rxIsId` hold their values until the next delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxLine | input | 1 | Serial receive line, high when idle |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| cfgSevenBit | input | 1 | 1: 7 data bits, 0: 8 data bits |
| cfgTwoStop | input | 1 | 1: two stop bits, 0: one stop bit |
| cfgMpEnable | input | 1 | Addressing mode on |
| cfgParityEn | input | 1 | Parity bit present (ignored in addressing mode) |
| cfgParityOdd | input | 1 | 1: odd parity, 0: even parity |
| stationId | input | 8 | This station's address |
| waitIdSet | input | 1 | Pulse that closes the receiver until its address arrives |
| hostRead | input | 1 | Pulse: byte read, error flags cleared |
| rxData | output | 8 | Last delivered character |
| rxValid | output | 1 | One-cycle delivery strobe |
| rxIsId | output | 1 | Delivered character was an address frame |
| waitId | output | 1 | Receiver is discarding data frames |
| frameErr | output | 1 | Sticky framing error |
| parityErr | output | 1 | Sticky parity error |
| overrun | output | 1 | Sticky overrun |

## Verification
The hardest state to reach from the ports is a data frame arriving right after a foreign address frame, when the receiver must drop it silently. The stimulus walks the receiver through the full sequence that gets there: closed, opened by its own address, closed by a foreign address, then reopened and closed again with `waitIdSet`. After each step it checks `waitId` and that nothing unexpected reached the scoreboard. Parity is left enabled during addressing mode, and payload bits are chosen so that they would fail the parity check, which shows that parity is really ignored. A stop-bit error is placed on the second stop bit as well as the first. Finally, the automatic host read is held off so that a second byte collides with an unread one and triggers an overrun.

// File: rtl/mprx_pkg.sv
package mprx_pkg;

  typedef struct packed {
    logic clearSr;
    logic capBit;
    logic capStop;
    logic loadOut;
  } rxStrobe_t;

  typedef struct packed {
    logic stopOk;
    logic extraBit;
    logic idMatch;
    logic parityOk;
  } frameInfo_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_RECV,
    ST_EVAL
  } rxState_e;

endpackage

// File: rtl/mprx_datapath.sv
module mprx_datapath
  import mprx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxLine,
  input  logic              cfgSevenBit,
  input  logic              cfgParityOdd,
  input  logic [DATA_W-1:0] stationId,
  input  rxStrobe_t         strobe,
  input  logic [IDX_W-1:0]  bitIdx,
  output frameInfo_t        info,
  output logic [DATA_W-1:0] rxData
);

  localparam int SR_W = DATA_W + 1;

  logic [SR_W-1:0]   payloadSr;
  logic              stopOk;
  logic [DATA_W-1:0] dataWord;
  logic [DATA_W-1:0] idMask;
  logic              extraBit;

  // Bits land at their own index, so a short data length leaves upper bits zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      payloadSr <= '0;
      stopOk    <= 1'b1;
    end else if (strobe.clearSr) begin
      payloadSr <= '0;
      stopOk    <= 1'b1;
    end else begin
      if (strobe.capBit) begin
        for (int i = 0; i < SR_W; i++) begin
          if (bitIdx == IDX_W'(i)) payloadSr[i] <= rxLine;
        end
      end
      if (strobe.capStop) stopOk <= stopOk & rxLine;
    end
  end

  always_comb begin
    if (cfgSevenBit) begin
      dataWord = {1'b0, payloadSr[DATA_W-2:0]};
      extraBit = payloadSr[DATA_W-1];
      idMask   = {1'b0, {(DATA_W-1){1'b1}}};
    end else begin
      dataWord = payloadSr[DATA_W-1:0];
      extraBit = payloadSr[DATA_W];
      idMask   = '1;
    end
  end

  assign info.stopOk   = stopOk;
  assign info.extraBit = extraBit;
  assign info.idMatch  = (dataWord == (stationId & idMask));
  assign info.parityOk = ((^dataWord) ^ extraBit) == cfgParityOdd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rxData <= '0;
    else if (strobe.loadOut) rxData <= dataWord;
  end

  // R1: the controller never clears, captures a data bit and captures a stop bit at once
  p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.clearSr, strobe.capBit, strobe.capStop}));

endmodule

// File: rtl/mprx_control.sv
module mprx_control
  import mprx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick16,
  input  logic             rxLine,
  input  logic             cfgSevenBit,
  input  logic             cfgTwoStop,
  input  logic             cfgMpEnable,
  input  logic             cfgParityEn,
  input  logic             waitIdSet,
  input  logic             hostRead,
  input  frameInfo_t       info,
  output rxStrobe_t        strobe,
  output logic [IDX_W-1:0] bitIdx,
  output logic             rxValid,
  output logic             rxIsId,
  output logic             waitId,
  output logic             frameErr,
  output logic             parityErr,
  output logic             overrun
);

  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);

  rxState_e         state;
  logic [CNT_W-1:0] tickCnt;
  logic             full;
  logic [IDX_W-1:0] nData, nPay, lastIdx;
  logic             sampleNow, frameBad, parBad, isIdFrame, wantDeliver;

  always_comb begin
    nData   = cfgSevenBit ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W);
    nPay    = nData + IDX_W'(cfgMpEnable | cfgParityEn);
    lastIdx = nPay + IDX_W'(cfgTwoStop);
  end

  assign sampleNow = (state == ST_RECV) && tick16 && (tickCnt == LAST_CNT);

  always_comb begin
    frameBad    = !info.stopOk;
    parBad      = !cfgMpEnable && cfgParityEn && !info.parityOk;
    isIdFrame   = cfgMpEnable && info.extraBit;
    wantDeliver = !frameBad && !parBad &&
                  (!cfgMpEnable || (isIdFrame ? info.idMatch : !waitId));
  end

  always_comb begin
    strobe.clearSr = (state == ST_START) && tick16 && (tickCnt == MID_CNT) && !rxLine;
    strobe.capBit  = sampleNow && (bitIdx < nPay);
    strobe.capStop = sampleNow && !(bitIdx < nPay);
    strobe.loadOut = (state == ST_EVAL) && wantDeliver && !full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      tickCnt   <= '0;
      bitIdx    <= '0;
      rxValid   <= 1'b0;
      rxIsId    <= 1'b0;
      waitId    <= 1'b1;
      full      <= 1'b0;
      frameErr  <= 1'b0;
      parityErr <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (hostRead) begin
        full      <= 1'b0;
        frameErr  <= 1'b0;
        parityErr <= 1'b0;
        overrun   <= 1'b0;
      end
      if (waitIdSet) waitId <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (tick16 && !rxLine) begin
            state   <= ST_START;
            tickCnt <= '0;
          end
        end
        ST_START: begin
          if (tick16) begin
            if (tickCnt == MID_CNT) begin
              state   <= rxLine ? ST_IDLE : ST_RECV;
              tickCnt <= '0;
              bitIdx  <= '0;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        ST_RECV: begin
          if (tick16) begin
            if (sampleNow) begin
              tickCnt <= '0;
              bitIdx  <= bitIdx + 1'b1;
              if (bitIdx == lastIdx) state <= ST_EVAL;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        ST_EVAL: begin
          state <= ST_IDLE;
          if (frameBad)                        frameErr  <= 1'b1;
          else if (parBad)                     parityErr <= 1'b1;
          else if (isIdFrame)                  waitId    <= !info.idMatch;
          if (wantDeliver) begin
            if (full) overrun <= 1'b1;
            else begin
              rxValid <= 1'b1;
              full    <= 1'b1;
              rxIsId  <= isIdFrame;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: the delivery strobe never stretches over two cycles
  p_valid_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |=> !rxValid);

  // R10: a delivery always leaves the byte marked unread
  p_valid_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |-> full);

  // R10: an overrun never coincides with a delivery
  p_overrun_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> !rxValid);

  // R4: an accepted address always opens the receiver
  p_id_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rxValid && rxIsId) |-> !waitId);

  // R6: data in addressing mode only passes while the receiver was open
  p_gated_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rxValid && !rxIsId && cfgMpEnable) |-> !$past(waitId));

  // R8: a framing error never comes with a delivery
  p_frame_err_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frameErr) |-> !rxValid);

endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import mprx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxLine,
  input  logic              tick16,
  input  logic              cfgSevenBit,
  input  logic              cfgTwoStop,
  input  logic              cfgMpEnable,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  input  logic [DATA_W-1:0] stationId,
  input  logic              waitIdSet,
  input  logic              hostRead,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxIsId,
  output logic              waitId,
  output logic              frameErr,
  output logic              parityErr,
  output logic              overrun
);

  localparam int IDX_W = $clog2(DATA_W + 4);

  rxStrobe_t        strobe;
  frameInfo_t       info;
  logic [IDX_W-1:0] bitIdx;

  mprx_control #(.OVS(OVS), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxLine(rxLine),
    .cfgSevenBit(cfgSevenBit), .cfgTwoStop(cfgTwoStop),
    .cfgMpEnable(cfgMpEnable), .cfgParityEn(cfgParityEn),
    .waitIdSet(waitIdSet), .hostRead(hostRead), .info(info),
    .strobe(strobe), .bitIdx(bitIdx), .rxValid(rxValid), .rxIsId(rxIsId),
    .waitId(waitId), .frameErr(frameErr), .parityErr(parityErr),
    .overrun(overrun)
  );

  mprx_datapath #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .rxLine(rxLine), .cfgSevenBit(cfgSevenBit),
    .cfgParityOdd(cfgParityOdd), .stationId(stationId), .strobe(strobe),
    .bitIdx(bitIdx), .info(info), .rxData(rxData)
  );

endmodule

// File: tb/test_mp_uart_rx.sv
module test_mp_uart_rx;

  localparam int BIT_CLK = 64;

  logic clk = 1'b0, rst_n = 1'b0, rxLine = 1'b1, tick16 = 1'b0;
  logic cfgSevenBit = 0, cfgTwoStop = 0, cfgMpEnable = 0, cfgParityEn = 0, cfgParityOdd = 0;
  logic [7:0] stationId = 8'h01;
  logic waitIdSet = 0, hostRead = 0;
  logic [7:0] rxData;
  logic rxValid, rxIsId, waitId, frameErr, parityErr, overrun;

  int checks = 0, failures = 0;
  logic [8:0] expQ[$];
  string tagQ[$];
  bit autoRead = 1, manualRead = 0, prevValid = 0, finished = 0;
  int tickDiv = 0;

  always #2.5 clk = ~clk;

  mp_uart_rx i_mp_uart_rx (
    .clk(clk), .rst_n(rst_n), .rxLine(rxLine), .tick16(tick16),
    .cfgSevenBit(cfgSevenBit), .cfgTwoStop(cfgTwoStop), .cfgMpEnable(cfgMpEnable),
    .cfgParityEn(cfgParityEn), .cfgParityOdd(cfgParityOdd), .stationId(stationId),
    .waitIdSet(waitIdSet), .hostRead(hostRead), .rxData(rxData), .rxValid(rxValid),
    .rxIsId(rxIsId), .waitId(waitId), .frameErr(frameErr), .parityErr(parityErr),
    .overrun(overrun)
  );

  always @(negedge clk) begin
    tickDiv <= (tickDiv == 3) ? 0 : tickDiv + 1;
    tick16  <= (tickDiv == 3);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every delivery and acknowledges the byte.
  always @(negedge clk) begin
    if (rst_n) begin
      if (prevValid && rxValid) chk(0, "R11 valid longer than one cycle", 1, 0);
      if (rxValid) begin
        if (expQ.size() == 0) chk(0, "unexpected delivery", {rxIsId, rxData}, 0);
        else begin
          logic [8:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk({rxIsId, rxData} == e, t, {rxIsId, rxData}, e);
        end
      end
      prevValid <= rxValid;
      hostRead  <= (autoRead && rxValid) || manualRead;
    end
  end

  task automatic expectItem(input logic [7:0] d, input bit isId, input string tag);
    expQ.push_back({isId, d});
    tagQ.push_back(tag);
  endtask

  // extra < 0: no flag/parity bit; badStop = index of the stop bit driven low, or -1
  task automatic sendFrame(input logic [7:0] d, input int nData, input int extra,
                           input int nStop, input int badStop);
    @(negedge clk);
    rxLine = 1'b0;
    repeat (BIT_CLK) @(negedge clk);
    for (int i = 0; i < nData; i++) begin
      rxLine = d[i];
      repeat (BIT_CLK) @(negedge clk);
    end
    if (extra >= 0) begin
      rxLine = extra[0];
      repeat (BIT_CLK) @(negedge clk);
    end
    for (int s = 0; s < nStop; s++) begin
      if (s == badStop) begin
        rxLine = 1'b0;
        repeat (40) @(negedge clk);
        rxLine = 1'b1;
        repeat (BIT_CLK - 40) @(negedge clk);
      end else begin
        rxLine = 1'b1;
        repeat (BIT_CLK) @(negedge clk);
      end
    end
    rxLine = 1'b1;
    repeat (2 * BIT_CLK) @(negedge clk);
  endtask

  task automatic drained(input string tag);
    chk(expQ.size() == 0, tag, expQ.size(), 0);
  endtask

  task automatic readByte();
    manualRead = 1;
    @(negedge clk);
    @(negedge clk);
    manualRead = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(rxValid == 0 && rxData == 0 && rxIsId == 0, "R7 reset outputs", {rxValid, rxIsId, rxData}, 0);
    chk(waitId == 1, "R7 reset waitId", waitId, 1);
    chk({frameErr, parityErr, overrun} == 0, "R7 reset flags", {frameErr, parityErr, overrun}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // Plain mode, 8 data bits, one and two stop bits
    expectItem(8'hA5, 0, "R2 plain 8-bit");     sendFrame(8'hA5, 8, -1, 1, -1);
    cfgTwoStop = 1;
    expectItem(8'h3C, 0, "R1 two stop bits");   sendFrame(8'h3C, 8, -1, 2, -1);
    cfgTwoStop = 0; cfgSevenBit = 1;
    expectItem(8'h55, 0, "R1 seven-bit");       sendFrame(8'h55, 7, -1, 1, -1);
    expectItem(8'h7F, 0, "R2 seven-bit top 0"); sendFrame(8'hFF, 7, -1, 1, -1);
    drained("R2 all plain frames delivered");

    // Parity in plain mode
    cfgSevenBit = 0; cfgParityEn = 1; cfgParityOdd = 0;
    expectItem(8'h03, 0, "R9 even parity ok"); sendFrame(8'h03, 8, 0, 1, -1);
    sendFrame(8'h07, 8, 0, 1, -1);
    chk(parityErr == 1, "R9 even parity error flag", parityErr, 1);
    drained("R9 bad parity frame dropped");
    readByte();
    chk(parityErr == 0, "R10 read clears parityErr", parityErr, 0);
    cfgParityOdd = 1;
    expectItem(8'h01, 0, "R9 odd parity ok"); sendFrame(8'h01, 8, 0, 1, -1);

    // Addressing mode; parity left enabled to show it is ignored
    cfgMpEnable = 1; stationId = 8'h01;
    sendFrame(8'hAA, 8, 0, 1, -1);
    drained("R6 data dropped while waiting");
    chk(waitId == 1, "R6 still waiting", waitId, 1);
    sendFrame(8'h02, 8, 1, 1, -1);
    drained("R5 foreign id dropped");
    chk(waitId == 1, "R5 waitId after foreign id", waitId, 1);
    expectItem(8'h01, 1, "R4 own id delivered"); sendFrame(8'h01, 8, 1, 1, -1);
    chk(waitId == 0, "R4 own id opens", waitId, 0);
    expectItem(8'hAA, 0, "R3 data passes, parity ignored"); sendFrame(8'hAA, 8, 0, 1, -1);
    chk(parityErr == 0, "R3 no parity error", parityErr, 0);
    sendFrame(8'h03, 8, 1, 1, -1);
    chk(waitId == 1, "R5 foreign id closes", waitId, 1);
    sendFrame(8'h11, 8, 0, 1, -1);
    drained("R6 data after foreign id dropped");

    expectItem(8'h01, 1, "R4 reopen"); sendFrame(8'h01, 8, 1, 1, -1);
    chk(waitId == 0, "R4 reopened", waitId, 0);
    waitIdSet = 1; @(negedge clk); waitIdSet = 0; @(negedge clk);
    chk(waitId == 1, "R7 waitIdSet closes", waitId, 1);
    sendFrame(8'h22, 8, 0, 1, -1);
    drained("R7 data dropped after waitIdSet");

    // Seven-bit addressing compares only the low 7 bits
    cfgSevenBit = 1; stationId = 8'h81;
    expectItem(8'h01, 1, "R4 seven-bit id match"); sendFrame(8'h01, 7, 1, 1, -1);
    expectItem(8'h45, 0, "R6 seven-bit data");     sendFrame(8'h45, 7, 0, 1, -1);
    cfgSevenBit = 0; stationId = 8'h01;

    // Framing errors on first and second stop bit
    sendFrame(8'h66, 8, 0, 1, 0);
    chk(frameErr == 1, "R8 stop low sets frameErr", frameErr, 1);
    chk(waitId == 0, "R8 waitId unchanged", waitId, 0);
    drained("R8 errored frame dropped");
    readByte();
    chk(frameErr == 0, "R10 read clears frameErr", frameErr, 0);
    cfgTwoStop = 1;
    sendFrame(8'h01, 8, 1, 2, 1);
    chk(frameErr == 1, "R8 second stop low", frameErr, 1);
    drained("R8 errored id dropped");
    readByte();
    cfgTwoStop = 0;

    // Overrun
    autoRead = 0;
    expectItem(8'h10, 0, "R10 first unread byte"); sendFrame(8'h10, 8, 0, 1, -1);
    sendFrame(8'h20, 8, 0, 1, -1);
    chk(overrun == 1, "R10 overrun set", overrun, 1);
    chk(rxData == 8'h10, "R10 older byte kept", rxData, 8'h10);
    readByte();
    chk(overrun == 0, "R10 read clears overrun", overrun, 0);
    autoRead = 1;

    // False start, then a normal frame
    @(negedge clk); rxLine = 0; repeat (16) @(negedge clk); rxLine = 1;
    repeat (3 * BIT_CLK) @(negedge clk);
    drained("R1 glitch ignored");
    expectItem(8'h5A, 0, "R1 frame after glitch"); sendFrame(8'h5A, 8, 0, 1, -1);
    drained("R1 frame after glitch arrived");
    repeat (20) @(negedge clk);
    chk(rxData == 8'h5A && rxValid == 0, "R11 data held, strobe low", {rxValid, rxData}, 8'h5A);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule